// File: doc/BRIEF.md
# Framed SPI Register-Access Slave

This block lets an external SPI master read and write single bytes in a 64 KiB byte-addressed space that sits behind a parallel memory port. The SPI side runs in mode 0. Each access is one fixed 32-bit frame inside one chip-select window. The frame carries four bytes in this order: a command byte, the high address byte, the low address byte, and a data byte. SCLK, chip select and MOSI are sampled into the system clock through two-flop synchronizers. All frame decoding and all memory strobes run in the system-clock domain.

While a frame is clocked in, MISO returns a fixed marker byte in each of the first three slots. In the fourth slot it returns the fetched byte for a read. Only one access is made per select window. The address does not advance. If the master keeps clocking after the 32nd bit, MISO returns all ones and the memory is not touched again until chip select is released. Each SCLK phase must last at least four system-clock periods.

The memory port has no back-pressure. A read request expects `mem_rdata` to hold the addressed byte in the clock cycle that follows the `mem_rd` pulse.

Top module: `spi_regport`

## Requirements
- R1: MOSI is sampled on rising SCLK edges, MSB first. The frame carries the command in bits 0-7, the high address byte in bits 8-15, the low address byte in bits 16-23 and the data byte in bits 24-31. The address is {high, low}.
- R2: Command 0xF0 is a write. After the 32nd bit, `mem_wr` is high for exactly one clock while `mem_addr` holds the frame address and `mem_wdata` holds the data byte.
- R3: Command 0x0F is a read. After the 24th bit, `mem_rd` is high for exactly one clock with `mem_addr` valid. The byte on `mem_rdata` in the following clock is returned in the fourth MISO slot.
- R4: MISO returns 0x00, 0x01 and 0x02 in the first three byte slots. In the fourth slot it returns the fetched byte for a read, 0x03 for a write, and 0x00 for any other command.
- R5: A command other than 0xF0 or 0x0F raises neither `mem_wr` nor `mem_rd`. `mem_wr` and `mem_rd` are never high together.
- R6: SCLK edges after the 32nd bit in the same select window make MISO output 1 on every bit (bytes of 0xFF). They raise no further strobe.
- R7: Releasing chip select before the 32nd bit aborts the frame without a write. The next frame starts again from bit 0.
- R8: MISO is low while chip select is inactive. While chip select is active, MISO changes only after falling SCLK edges.
- R9: During and after reset, `mem_wr`, `mem_rd` and `spi_miso` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the master (mode 0) |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 8 | Byte to write |
| mem_wr | output | 1 | One-clock write strobe |
| mem_rd | output | 1 | One-clock read strobe |
| mem_rdata | input | 8 | Read byte, valid the clock after `mem_rd` |

## Verification
The embedded assertions check on every cycle that each strobe lasts one clock, that a read and a write never coincide, that the bit counter never passes the frame length, and that MISO stays low while chip select is released. Only the bench's frames can show the rest: bit ordering, address assembly, the slot marker bytes, the returned read byte, the 0xFF overrun bytes, and the suppressed write after an aborted frame. These all depend on full multi-byte sequences on the SPI pins.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam logic [7:0] CMD_WRITE = 8'hF0;
  localparam logic [7:0] CMD_READ  = 8'h0F;
  localparam logic [7:0] WRITE_ACK = 8'h03;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= rst_val;
      end else if (s == 0) begin
        stage_q[s] <= din;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int FRAME_END = 2*DW + AW,
  localparam int CW = $clog2(FRAME_END + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          csn_s,
  input  logic          mosi_s,
  output logic          active,
  output logic          sclk_fall,
  output logic [CW-1:0] bit_cnt,
  output acc_kind_e     acc,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          mem_wr,
  output logic          mem_rd
);
  localparam int OP_END   = DW;
  localparam int ADDR_END = DW + AW;

  logic          sclk_q;
  logic          sclk_rise;
  logic          shifted_q;
  logic [AW-1:0] sr_q;
  logic [AW-1:0] sr_next;
  logic [CW-1:0] cnt_inc;
  acc_kind_e     acc_dec;

  assign active    = ~csn_s;
  assign sclk_rise = active &  sclk_s & ~sclk_q;
  assign sclk_fall = active & ~sclk_s &  sclk_q;
  assign sr_next   = {sr_q[AW-2:0], mosi_s};
  assign cnt_inc   = bit_cnt + CW'(1);

  always_comb begin
    unique case (sr_next[DW-1:0])
      CMD_WRITE: acc_dec = ACC_WRITE;
      CMD_READ:  acc_dec = ACC_READ;
      default:   acc_dec = ACC_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      shifted_q <= 1'b0;
      sr_q      <= '0;
      bit_cnt   <= '0;
      acc       <= ACC_NONE;
      addr      <= '0;
      wdata     <= '0;
    end else begin
      sclk_q    <= sclk_s;
      shifted_q <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
        acc     <= ACC_NONE;
      end else if (sclk_rise && bit_cnt != CW'(FRAME_END)) begin
        sr_q      <= sr_next;
        bit_cnt   <= cnt_inc;
        shifted_q <= 1'b1;
        if (cnt_inc == CW'(OP_END))    acc   <= acc_dec;
        if (cnt_inc == CW'(ADDR_END))  addr  <= sr_next;
        if (cnt_inc == CW'(FRAME_END)) wdata <= sr_next[DW-1:0];
      end
    end
  end

  assign mem_wr = shifted_q && (bit_cnt == CW'(FRAME_END)) && (acc == ACC_WRITE);
  assign mem_rd = shifted_q && (bit_cnt == CW'(ADDR_END))  && (acc == ACC_READ);

  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R5
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(FRAME_END));
  // R7
  wr_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(active));
endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx
  import spi_regport_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int FRAME_END = 2*DW + AW,
  localparam int CW = $clog2(FRAME_END + 1),
  localparam int LW = $clog2(DW),
  localparam int LAST_SLOT = FRAME_END/DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          sclk_fall,
  input  logic [CW-1:0] bit_cnt,
  input  acc_kind_e     acc,
  input  logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          miso
);
  logic          rd_q;
  logic [DW-1:0] rbuf_q;
  logic [DW-1:0] tx_byte;
  logic [CW-LW-1:0] slot;
  logic [LW-1:0]    bit_idx;

  assign slot    = bit_cnt[CW-1:LW];
  assign bit_idx = bit_cnt[LW-1:0];

  always_comb begin
    if (bit_cnt >= CW'(FRAME_END)) begin
      tx_byte = '1;
    end else if (slot == (CW-LW)'(LAST_SLOT)) begin
      unique case (acc)
        ACC_READ:  tx_byte = rbuf_q;
        ACC_WRITE: tx_byte = DW'(WRITE_ACK);
        default:   tx_byte = '0;
      endcase
    end else begin
      tx_byte = DW'(slot);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      rbuf_q <= '0;
      miso   <= 1'b0;
    end else begin
      rd_q <= mem_rd;
      if (rd_q) rbuf_q <= mem_rdata;
      if (!active)        miso <= 1'b0;
      else if (sclk_fall) miso <= tx_byte[~bit_idx];
    end
  end

  // R8
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !miso);
  // R8
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(sclk_fall)) |-> $stable(miso));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_csn,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata
);
  localparam int FRAME_END = 2*DW + AW;
  localparam int CW = $clog2(FRAME_END + 1);

  logic [2:0]    pins_s;
  logic          active;
  logic          sclk_fall;
  logic [CW-1:0] bit_cnt;
  acc_kind_e     acc;

  spi_regport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     ({spi_sclk, spi_csn, spi_mosi}),
    .rst_val (3'b010),
    .dout    (pins_s)
  );

  spi_regport_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[2]),
    .csn_s     (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .active    (active),
    .sclk_fall (sclk_fall),
    .bit_cnt   (bit_cnt),
    .acc       (acc),
    .addr      (mem_addr),
    .wdata     (mem_wdata),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd)
  );

  spi_regport_tx #(.AW(AW), .DW(DW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .sclk_fall (sclk_fall),
    .bit_cnt   (bit_cnt),
    .acc       (acc),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .miso      (spi_miso)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!mem_wr && !mem_rd && !spi_miso));
endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_csn = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_wr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = 8'h00;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [15:0] wr_addr_seen = '0;
  logic [7:0]  wr_data_seen = '0;
  logic [15:0] rd_addr_seen = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_regport u_spi_regport (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[15:8] ^ {a[6:0], a[7]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata    <= mem_f(mem_addr);
      rd_cnt       <= rd_cnt + 1;
      rd_addr_seen <= mem_addr;
    end
    if (mem_wr) begin
      wr_cnt       <= wr_cnt + 1;
      wr_addr_seen <= mem_addr;
      wr_data_seen <= mem_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one select window of nbits; returns MISO bits sampled before each rise.
  task automatic frame(input logic [31:0] word, input int nbits, output logic [63:0] rx);
    rx = '0;
    spi_csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 32) ? word[31-i] : 1'b1;
      wait_clk(HALF);
      rx = {rx[62:0], spi_miso};
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
    wait_clk(HALF);
    spi_csn = 1'b1;
    wait_clk(2 * HALF);
  endtask

  function automatic logic [7:0] rx_byte(input logic [63:0] rx, input int nbits, input int k);
    return rx[nbits-1-8*k -: 8];
  endfunction

  // {command, address, data}
  localparam logic [31:0] VEC [6] = '{
    32'hF0_1234_A5,
    32'h0F_1234_00,
    32'h0F_FFFF_11,
    32'hF0_0000_3C,
    32'h55_ABCD_77,
    32'h0F_00FF_00
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] rx;
    int w0, r0;
    // R9 reset state
    wait_clk(4);
    chk("R9 wr in reset", {31'd0, mem_wr}, 0);
    chk("R9 rd in reset", {31'd0, mem_rd}, 0);
    chk("R9 miso in reset", {31'd0, spi_miso}, 0);
    rst_n = 1'b1;
    wait_clk(6);
    chk("R9 miso after reset", {31'd0, spi_miso}, 0);

    foreach (VEC[v]) begin
      logic [7:0] op;
      logic [15:0] a;
      logic [7:0] d;
      logic [7:0] exp3;
      op = VEC[v][31:24]; a = VEC[v][23:8]; d = VEC[v][7:0];
      w0 = wr_cnt; r0 = rd_cnt;
      frame(VEC[v], 32, rx);
      // R4 marker bytes
      for (int k = 0; k < 3; k++) chk("R4 slot marker", rx_byte(rx, 32, k), k);
      exp3 = (op == 8'h0F) ? mem_f(a) : (op == 8'hF0) ? 8'h03 : 8'h00;
      chk("R3 R4 fourth slot", rx_byte(rx, 32, 3), exp3);
      chk("R2 R5 write count", wr_cnt - w0, (op == 8'hF0) ? 1 : 0);
      chk("R3 R5 read count", rd_cnt - r0, (op == 8'h0F) ? 1 : 0);
      if (op == 8'hF0) begin
        chk("R1 R2 write address", wr_addr_seen, a);
        chk("R1 R2 write data", wr_data_seen, d);
      end
      if (op == 8'h0F) chk("R1 R3 read address", rd_addr_seen, a);
      // R8 idle MISO
      chk("R8 miso idle", {31'd0, spi_miso}, 0);
    end

    // R6 overrun on a write
    w0 = wr_cnt; r0 = rd_cnt;
    frame(32'hF0_0042_99, 48, rx);
    chk("R6 byte4 ones", rx_byte(rx, 48, 4), 8'hFF);
    chk("R6 byte5 ones", rx_byte(rx, 48, 5), 8'hFF);
    chk("R6 single write", wr_cnt - w0, 1);
    chk("R6 no read", rd_cnt - r0, 0);
    chk("R2 overrun address", wr_addr_seen, 16'h0042);

    // R6 overrun on a read
    r0 = rd_cnt;
    frame(32'h0F_0042_00, 48, rx);
    chk("R6 read byte3", rx_byte(rx, 48, 3), mem_f(16'h0042));
    chk("R6 read byte5 ones", rx_byte(rx, 48, 5), 8'hFF);
    chk("R6 single read", rd_cnt - r0, 1);

    // R7 abort after 28 bits
    w0 = wr_cnt;
    frame(32'hF0_7777_EE, 28, rx);
    chk("R7 aborted write", wr_cnt - w0, 0);
    frame(32'hF0_0101_C3, 32, rx);
    chk("R7 next frame write", wr_cnt - w0, 1);
    chk("R7 next frame address", wr_addr_seen, 16'h0101);
    chk("R7 next frame data", wr_data_seen, 8'hC3);
    chk("R7 next frame markers", rx[31:8], 24'h000102);

    // R8 MISO held while select high with SCLK toggling
    for (int i = 0; i < 4; i++) begin
      spi_sclk = 1'b1; wait_clk(HALF);
      spi_sclk = 1'b0; wait_clk(HALF);
    end
    chk("R8 miso while deselected", {31'd0, spi_miso}, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule